// File: doc/BRIEF.md
# Control Loop Stage Sequencer

This block schedules one iteration of a motor-control feedback loop from a single counter. The counter steps through a fixed number of phases per loop. At fixed phase values it starts each processing stage and tells the next stage when to capture the previous stage's result. There are four stages, served in this order: current acquisition (7 cycles), torque and flux estimation (48 cycles), the hysteresis comparators and sector lookup working side by side (7 cycles), and the inverter switching lookup (4 cycles). With these defaults the loop is 66 cycles long.

Stages do not handshake with each other. Each start strobe is a one-cycle pulse on the first phase of its stage. Each capture strobe is a one-cycle pulse on the last phase of its stage. The next stage therefore starts on the cycle after the previous stage is captured. A loop-complete pulse marks the final phase, and a wrapping counter records how many loops have completed.

The `run` input pauses the schedule and `rst` is a synchronous restart. Stage lengths are parameters, and every phase offset is derived from them.

Top module: `loop_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, the phase returns to 0 and `iter_count` becomes 0 at that edge. While `rst` is high, every strobe and `loop_done` stays low.
- R2: While `run` is high, the phase advances by one each cycle from 0 to 65 and then wraps to 0, so a loop takes 66 enabled cycles.
- R3: `stage_start` bit 0 (acquisition), bit 1 (estimation), bit 2 (comparator and sector) and bit 3 (switching lookup) each pulse for one cycle when the phase is 0, 7, 55 and 62 respectively and `run` is high. At most one bit is set in any cycle.
- R4: The same bits of `stage_latch` pulse when the phase is 6, 54, 61 and 65 respectively and `run` is high. At most one bit is set in any cycle.
- R5: `loop_done` is high exactly when the phase is 65 and `run` is high. This is the same cycle as `stage_latch` bit 3.
- R6: While `run` is low, the phase holds and all strobes and `loop_done` stay low. When `run` returns high, the schedule resumes from the held phase without repeating or skipping a pulse.
- R7: `iter_count` increases by one on the clock edge that ends each cycle in which `loop_done` is high. It wraps modulo 2^ITER_W and otherwise holds.
- R8: After the capture pulse of stages 0 to 2, the next enabled cycle carries the start pulse of the following stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous restart, active high |
| run | input | 1 | Advance enable; low pauses the schedule |
| stage_start | output | 4 | One-cycle start strobe per stage |
| stage_latch | output | 4 | One-cycle result-capture strobe per stage |
| loop_done | output | 1 | High on the final phase of a loop |
| iter_count | output | ITER_W | Completed loops, wrapping |

## Verification
At phase 65, three things coincide in one cycle: the capture strobe of the switching stage, the loop-complete pulse and the counter wrap. The next edge also bumps the loop counter. The bench provokes this by running full loops and by holding `run` low exactly on phase 65, and on each other stage boundary, for several cycles. A reference model predicts every output cycle by cycle from the stage lengths, and the bench compares against it. Restart is also applied mid-loop with `run` high, so that the restart and an advance compete in the same cycle; the restart must win.

// File: rtl/stage_seq_pkg.sv
package stage_seq_pkg;

   localparam int NSTG = 4;
   localparam int LW   = 16;

   typedef logic [NSTG*LW-1:0] len_vec_t;

   function automatic int stage_len(input len_vec_t v, input int idx);
      return int'(v[idx*LW +: LW]);
   endfunction

   function automatic int stage_first(input len_vec_t v, input int idx);
      int acc;
      acc = 0;
      for (int k = 0; k < NSTG; k++) begin
         if (k < idx) acc += stage_len(v, k);
      end
      return acc;
   endfunction

   function automatic int stage_last(input len_vec_t v, input int idx);
      return stage_first(v, idx) + stage_len(v, idx) - 1;
   endfunction

   function automatic int loop_len(input len_vec_t v);
      return stage_first(v, NSTG);
   endfunction

endpackage

// File: rtl/seq_counter.sv
module seq_counter #(
   parameter int LEN = 66,
   parameter int W   = 7
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         adv,
   output logic [W-1:0] cnt,
   output logic         at_end
);

   initial begin
      assert (LEN > 1) else $error("seq_counter: LEN must exceed 1");
      assert ((1 << W) >= LEN) else $error("seq_counter: W too narrow");
   end

   assign at_end = (cnt == W'(LEN - 1));

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= '0;
      else if (adv)
         cnt <= at_end ? '0 : cnt + W'(1);
   end

   assert_restart_R1: assert property (@(posedge clk) rst |=> cnt == '0);
   assert_range_R2:   assert property (@(posedge clk) disable iff (rst) cnt < W'(LEN));
   assert_wrap_R2:    assert property (@(posedge clk) disable iff (rst) (adv && at_end) |=> cnt == '0);
   assert_hold_R6:    assert property (@(posedge clk) disable iff (rst) !adv |=> $stable(cnt));

endmodule

// File: rtl/stage_decode.sv
module stage_decode
   import stage_seq_pkg::*;
#(
   parameter len_vec_t LENS = '0,
   parameter int       W    = 7
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            active,
   input  logic [W-1:0]    phase,
   output logic [NSTG-1:0] start,
   output logic [NSTG-1:0] latch
);

   for (genvar i = 0; i < NSTG; i++) begin : g_stage
      localparam int FIRST = stage_first(LENS, i);
      localparam int LAST  = stage_last(LENS, i);

      initial begin
         assert (stage_len(LENS, i) >= 1) else $error("stage_decode: empty stage");
      end

      assign start[i] = active && (phase == W'(FIRST));
      assign latch[i] = active && (phase == W'(LAST));

      if (i < NSTG - 1) begin : g_hand
         localparam int NEXT = stage_first(LENS, i + 1);
         assert_handoff_R8: assert property (@(posedge clk) disable iff (rst)
            latch[i] |=> phase == W'(NEXT));
      end
   end

   assert_start_single_R3: assert property (@(posedge clk) disable iff (rst) $onehot0(start));
   assert_latch_single_R4: assert property (@(posedge clk) disable iff (rst) $onehot0(latch));
   assert_quiet_R6:        assert property (@(posedge clk) !active |-> (start == '0 && latch == '0));

endmodule

// File: rtl/iter_counter.sv
module iter_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         bump,
   output logic [W-1:0] count
);

   initial begin
      assert (W >= 1) else $error("iter_counter: W must be positive");
   end

   always_ff @(posedge clk) begin
      if (rst)
         count <= '0;
      else if (bump)
         count <= count + W'(1);
   end

   assert_iter_clear_R1: assert property (@(posedge clk) rst |=> count == '0);
   assert_iter_step_R7:  assert property (@(posedge clk) disable iff (rst)
      bump |=> count == $past(count) + W'(1));
   assert_iter_hold_R7:  assert property (@(posedge clk) disable iff (rst)
      !bump |=> $stable(count));

endmodule

// File: rtl/loop_sequencer.sv
module loop_sequencer
   import stage_seq_pkg::*;
#(
   parameter int ACQ_LEN = 7,
   parameter int EST_LEN = 48,
   parameter int CMP_LEN = 7,
   parameter int SWT_LEN = 4,
   parameter int ITER_W  = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              run,
   output logic [NSTG-1:0]   stage_start,
   output logic [NSTG-1:0]   stage_latch,
   output logic              loop_done,
   output logic [ITER_W-1:0] iter_count
);

   localparam len_vec_t LENS = {LW'(SWT_LEN), LW'(CMP_LEN), LW'(EST_LEN), LW'(ACQ_LEN)};
   localparam int LOOP_LEN = loop_len(LENS);
   localparam int CNT_W    = $clog2(LOOP_LEN);

   initial begin
      assert (ACQ_LEN > 0 && EST_LEN > 0 && CMP_LEN > 0 && SWT_LEN > 0)
         else $error("loop_sequencer: stage lengths must be positive");
      assert (LOOP_LEN < (1 << LW)) else $error("loop_sequencer: loop too long");
   end

   logic [CNT_W-1:0] phase;
   logic             last_phase;
   logic             active;

   assign active    = run & ~rst;
   assign loop_done = active & last_phase;

   seq_counter #(.LEN(LOOP_LEN), .W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .adv    (run),
      .cnt    (phase),
      .at_end (last_phase)
   );

   stage_decode #(.LENS(LENS), .W(CNT_W)) u_dec (
      .clk    (clk),
      .rst    (rst),
      .active (active),
      .phase  (phase),
      .start  (stage_start),
      .latch  (stage_latch)
   );

   iter_counter #(.W(ITER_W)) u_iter (
      .clk   (clk),
      .rst   (rst),
      .bump  (loop_done),
      .count (iter_count)
   );

   assert_done_with_last_R5: assert property (@(posedge clk) disable iff (rst)
      loop_done |-> stage_latch[NSTG-1]);
   assert_done_then_start_R5: assert property (@(posedge clk) disable iff (rst)
      (loop_done && run) |=> (!run || stage_start[0]));

endmodule

// File: tb/sim_loop_sequencer.sv
`timescale 1ns/1ps
module sim_loop_sequencer;

   localparam int IW = 4;
   localparam int L0 = 7, L1 = 48, L2 = 7, L3 = 4;
   localparam int F0 = 0, F1 = L0, F2 = L0 + L1, F3 = L0 + L1 + L2;
   localparam int LOOP = F3 + L3;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          run = 1'b0;
   logic [3:0]    stage_start;
   logic [3:0]    stage_latch;
   logic          loop_done;
   logic [IW-1:0] iter_count;

   int n_chk  = 0;
   int n_fail = 0;
   int m_cnt  = 0;
   int m_it   = 0;

   always #2.5 clk = ~clk;

   loop_sequencer #(.ITER_W(IW)) u0 (
      .clk         (clk),
      .rst         (rst),
      .run         (run),
      .stage_start (stage_start),
      .stage_latch (stage_latch),
      .loop_done   (loop_done),
      .iter_count  (iter_count)
   );

   task automatic chk(input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (phase model %0d)", what, act, exp, m_cnt);
      end
   endtask

   task automatic step(input logic r, input logic go, input string tag);
      int en, es, el, ed;
      int firsts[4];
      int lens[4];
      firsts = '{F0, F1, F2, F3};
      lens   = '{L0, L1, L2, L3};
      @(negedge clk);
      rst = r;
      run = go;
      #1;
      en = (go && !r) ? 1 : 0;
      es = 0;
      el = 0;
      for (int s = 0; s < 4; s++) begin
         if (en != 0 && m_cnt == firsts[s]) es |= (1 << s);
         if (en != 0 && m_cnt == firsts[s] + lens[s] - 1) el |= (1 << s);
      end
      ed = (en != 0 && m_cnt == LOOP - 1) ? 1 : 0;
      chk({tag, " start R3"}, int'(stage_start), es);
      chk({tag, " latch R4"}, int'(stage_latch), el);
      chk({tag, " done R5"}, int'(loop_done), ed);
      chk({tag, " iter R7"}, int'(iter_count), m_it);
      @(posedge clk);
      if (r) begin
         m_cnt = 0;
         m_it  = 0;
      end else if (go) begin
         if (m_cnt == LOOP - 1) begin
            m_cnt = 0;
            m_it  = (m_it + 1) % (1 << IW);
         end else begin
            m_cnt = m_cnt + 1;
         end
      end
   endtask

   task automatic run_to(input int target, input string tag);
      for (int g = 0; g < 2 * LOOP && m_cnt != target; g++) step(1'b0, 1'b1, tag);
   endtask

   initial begin
      rst = 1'b1;
      run = 1'b0;
      repeat (2) @(posedge clk);
      m_cnt = 0;
      m_it  = 0;

      // R1: outputs quiet while restart is held, even with run high
      for (int k = 0; k < 3; k++) step(1'b1, 1'b1, "R1 reset");

      // R2: three uninterrupted loops, wrap at 65
      for (int k = 0; k < 3 * LOOP; k++) step(1'b0, 1'b1, "R2 steady");

      // R6: run toggling in a two-on one-off pattern
      for (int k = 0; k < 4 * LOOP; k++) step(1'b0, (k % 3) != 0, "R6 toggle");

      // R6/R8: pause on each stage boundary, including phase 65
      begin
         int marks[8];
         marks = '{0, 6, 7, 54, 55, 61, 62, 65};
         foreach (marks[j]) begin
            run_to(marks[j], "R8 approach");
            for (int k = 0; k < 3; k++) step(1'b0, 1'b0, "R6 pause");
            for (int k = 0; k < 3; k++) step(1'b0, 1'b1, "R8 resume");
         end
      end

      // R1: restart mid-loop while run is high, and with run low
      run_to(30, "R1 approach");
      step(1'b1, 1'b1, "R1 midloop");
      for (int k = 0; k < LOOP + 2; k++) step(1'b0, 1'b1, "R1 after");
      run_to(40, "R1 approach");
      step(1'b1, 1'b0, "R1 idle restart");
      step(1'b0, 1'b0, "R1 idle hold");

      // R7: enough loops to wrap the iteration counter
      for (int k = 0; k < ((1 << IW) + 1) * LOOP + 5; k++) step(1'b0, 1'b1, "R7 wrap");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule